// File: doc/BRIEF.md
# Byte-Lane Parity Error Capture

This block guards a 32-bit external memory built from two banks, with one parity bit stored beside every byte. On the write side it forms the four parity bits from the outgoing word without any delay, so they can be stored with the data. On the read side it compares each returned byte with the parity bit that came back with it.

While checking is on, the first read that fails is held. The block keeps a sticky flag, the number of the failing byte lane and the bank the address fell in. Each later failure is ignored until software turns checking off, which clears the capture, and then turns it on again. Nothing is signalled to the host when a failure is caught, so software has to poll the capture outputs.

A second control bit can drive the sticky flag onto the upstream error line. Reads from the small on-chip region at the bottom of the address space are never checked. The memory is modelled as a single-cycle read strobe that carries address, data and parity.

Top module: `lane_parity_guard`

## Requirements
- R1: For each lane i (data bits 8i+7..8i), `wr_par[i]` gives odd parity: the byte and its parity bit together hold an odd number of ones. This output is combinational.
- R2: A read whose lanes all have odd parity does not set the flag.
- R3: While checking is enabled and no error is held, a read with a parity failure sets `err_flag` at the next clock edge. The same edge loads `err_lane` with the failing lane number and `err_bank` with address bit 20 (0 is the first megabyte, 1 the second).
- R4: If several lanes fail in one read, `err_lane` holds the lowest-numbered failing lane.
- R5: While an error is held and checking stays enabled, later failures change neither the flag, the lane nor the bank.
- R6: At the clock edge after the enable register goes to 0, the flag, lane and bank are cleared. While checking is disabled, failing reads leave them at 0.
- R7: Reads whose byte address is below 2048 (the on-chip region) are never checked.
- R8: `up_err` follows `err_flag` when the route bit is 1 and is held at 0 when the route bit is 0.
- R9: After reset, `err_flag`, `err_lane`, `err_bank` and `up_err` are 0, and checking and routing are both off. Software must still write the enable before it relies on checking.
- R10: When `rd_valid` is low, bad data or bad parity on the read inputs has no effect.
- R11: Pulsing `ctl_wr` loads the enable from `ctl_check_en` and the route bit from `ctl_route` at the next edge. The enable bit cannot be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Strobe that loads the control bits |
| ctl_check_en | input | 1 | Value loaded into the checking enable |
| ctl_route | input | 1 | Value loaded into the upstream route bit |
| wr_data | input | 32 | Word being written to memory |
| wr_par | output | 4 | Odd parity bit for each write lane |
| rd_valid | input | 1 | Read data, parity and address are valid this cycle |
| rd_addr | input | 21 | Byte address of the read |
| rd_data | input | 32 | Word returned by memory |
| rd_par | input | 4 | Parity bits returned with the word |
| err_flag | output | 1 | Sticky flag that an error has been captured |
| err_lane | output | 2 | Lane number of the captured error |
| err_bank | output | 1 | Bank of the captured error |
| up_err | output | 1 | Upstream error line |

## Verification
The properties assume that `rd_valid`, `rd_addr`, `rd_data` and `rd_par` are never unknown and change only between clock edges. They also assume that the control bits are loaded only through `ctl_wr`. The capture property compares against the address and data of the cycle before, so the inputs must hold still across the sampling edge. The bench meets this by driving every input on the falling edge and by keeping each read strobe to a single cycle. It also writes the enable before the first checked read.

// File: rtl/lane_parity_guard.sv
module lane_parity_guard #(
  parameter int LANES        = 4,
  parameter int BYTE_W       = 8,
  parameter int ADDR_W       = 21,
  parameter int BANK_BIT     = 20,
  parameter int ONCHIP_BYTES = 2048
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_wr,
  input  logic                     ctl_check_en,
  input  logic                     ctl_route,
  input  logic [LANES*BYTE_W-1:0]  wr_data,
  output logic [LANES-1:0]         wr_par,
  input  logic                     rd_valid,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [LANES*BYTE_W-1:0]  rd_data,
  input  logic [LANES-1:0]         rd_par,
  output logic                     err_flag,
  output logic [$clog2(LANES)-1:0] err_lane,
  output logic                     err_bank,
  output logic                     up_err
);
  localparam int LANE_W = $clog2(LANES);
  localparam logic [ADDR_W-1:0] ONCHIP_LIM = ADDR_W'(ONCHIP_BYTES);

  logic              en_q, route_q;
  logic [LANES-1:0]  bad;
  logic [LANE_W-1:0] hit_lane;
  logic              checked;

  assign checked = rd_valid && (rd_addr >= ONCHIP_LIM);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_par[g] = ~^wr_data[g*BYTE_W +: BYTE_W];
    assign bad[g]    = checked && !(^{rd_data[g*BYTE_W +: BYTE_W], rd_par[g]});
  end

  always_comb begin
    hit_lane = '0;
    for (int i = LANES-1; i >= 0; i--)
      if (bad[i]) hit_lane = LANE_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      route_q <= 1'b0;
    end else if (ctl_wr) begin
      en_q    <= ctl_check_en;
      route_q <= ctl_route;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_q) begin
      err_flag <= 1'b0;
      err_lane <= '0;
      err_bank <= 1'b0;
    end else if (!err_flag && |bad) begin
      err_flag <= 1'b1;
      err_lane <= hit_lane;
      err_bank <= rd_addr[BANK_BIT];
    end
  end

  assign up_err = route_q & err_flag;
endmodule

// File: rtl/lane_parity_guard_chk.sv
module lane_parity_guard_chk #(
  parameter int LANES        = 4,
  parameter int BYTE_W       = 8,
  parameter int ADDR_W       = 21,
  parameter int BANK_BIT     = 20,
  parameter int ONCHIP_BYTES = 2048
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     en_q,
  input logic [LANES*BYTE_W-1:0]  wr_data,
  input logic [LANES-1:0]         wr_par,
  input logic                     rd_valid,
  input logic [ADDR_W-1:0]        rd_addr,
  input logic [LANES*BYTE_W-1:0]  rd_data,
  input logic [LANES-1:0]         rd_par,
  input logic                     err_flag,
  input logic [$clog2(LANES)-1:0] err_lane,
  input logic                     err_bank,
  input logic                     up_err
);
  localparam logic [ADDR_W-1:0] LIM = ADDR_W'(ONCHIP_BYTES);

  always_comb
    for (int i = 0; i < LANES; i++)
      a_wr_odd_r1: assert (^{wr_data[i*BYTE_W +: BYTE_W], wr_par[i]} == 1'b1);

  p_first_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !err_flag && rd_valid && rd_addr >= LIM && !(^{rd_data[BYTE_W-1:0], rd_par[0]}))
    |=> (err_flag && err_lane == '0 && err_bank == $past(rd_addr[BANK_BIT])));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && err_flag) |=> (!err_flag || ($stable(err_lane) && $stable(err_bank))));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (!err_flag && err_lane == '0 && !err_bank));

  p_onchip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_addr < LIM && !err_flag) |=> !err_flag);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !err_flag) |=> !err_flag);

  p_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_err |-> err_flag);
endmodule

bind lane_parity_guard lane_parity_guard_chk #(
  .LANES(LANES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
  .BANK_BIT(BANK_BIT), .ONCHIP_BYTES(ONCHIP_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .wr_data(wr_data), .wr_par(wr_par),
  .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_par(rd_par),
  .err_flag(err_flag), .err_lane(err_lane), .err_bank(err_bank), .up_err(up_err)
);

// File: tb/lane_parity_guard_bench.sv
module lane_parity_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0, ctl_check_en = 1'b0, ctl_route = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_par;
  logic        rd_valid = 1'b0;
  logic [20:0] rd_addr = '0;
  logic [31:0] rd_data = '0;
  logic [3:0]  rd_par = '0;
  logic        err_flag, err_bank, up_err;
  logic [1:0]  err_lane;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lane_parity_guard u_lane_parity_guard (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_check_en(ctl_check_en),
    .ctl_route(ctl_route), .wr_data(wr_data), .wr_par(wr_par),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_par(rd_par),
    .err_flag(err_flag), .err_lane(err_lane), .err_bank(err_bank), .up_err(up_err)
  );

  function automatic logic [3:0] good_par(logic [31:0] d);
    for (int i = 0; i < 4; i++) good_par[i] = ~^d[i*8 +: 8];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ctl(logic en, logic rt);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_check_en = en; ctl_route = rt;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic do_read(logic [20:0] a, logic [31:0] d, logic [3:0] p);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; rd_data = d; rd_par = p;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic rearm();
    set_ctl(1'b0, 1'b0);
    @(negedge clk);
    set_ctl(1'b1, 1'b0);
  endtask

  task automatic t_reset();
    check("R9 flag", err_flag, 0);
    check("R9 lane", err_lane, 0);
    check("R9 bank", err_bank, 0);
    check("R9 up_err", up_err, 0);
  endtask

  task automatic t_wr_parity();
    logic [31:0] pats[4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0102_0380, 32'hA5C3_7E01};
    foreach (pats[k]) begin
      wr_data = pats[k];
      #1;
      check("R1 wr_par", wr_par, good_par(pats[k]));
    end
  endtask

  task automatic t_clean_read();
    set_ctl(1'b1, 1'b0);
    do_read(21'h000900, 32'h1234_5678, good_par(32'h1234_5678));
    do_read(21'h100040, 32'hFFFF_0000, good_par(32'hFFFF_0000));
    check("R2 clean reads", err_flag, 0);
  endtask

  task automatic t_single_error();
    do_read(21'h100010, 32'hDEAD_BEEF, good_par(32'hDEAD_BEEF) ^ 4'b0100);
    check("R3 flag", err_flag, 1);
    check("R3 lane", err_lane, 2);
    check("R3 bank", err_bank, 1);
    rearm();
    do_read(21'h000804, 32'h0, good_par(32'h0) ^ 4'b1000);
    check("R3 lane3", err_lane, 3);
    check("R3 bank0", err_bank, 0);
  endtask

  task automatic t_lowest_lane();
    rearm();
    do_read(21'h100800, 32'h55AA_55AA, good_par(32'h55AA_55AA) ^ 4'b1010);
    check("R4 lowest lane", err_lane, 1);
    check("R4 flag", err_flag, 1);
  endtask

  task automatic t_sticky();
    do_read(21'h000A00, 32'h0, good_par(32'h0) ^ 4'b0001);
    check("R5 lane held", err_lane, 1);
    check("R5 bank held", err_bank, 1);
    check("R5 flag held", err_flag, 1);
  endtask

  task automatic t_disable();
    set_ctl(1'b0, 1'b0);
    @(negedge clk);
    check("R6 cleared flag", err_flag, 0);
    check("R6 cleared lane", err_lane, 0);
    check("R6 cleared bank", err_bank, 0);
    do_read(21'h100100, 32'h0, 4'h0);
    check("R6 ignored while off", err_flag, 0);
    set_ctl(1'b1, 1'b0);
    check("R11 enable loaded, no stale capture", err_flag, 0);
  endtask

  task automatic t_onchip();
    do_read(21'h0007FC, 32'h0, 4'h0);
    do_read(21'h000000, 32'hFF, 4'h0);
    check("R7 on-chip unchecked", err_flag, 0);
    do_read(21'h000800, 32'h0, 4'h0);
    check("R7 first external byte checked", err_flag, 1);
  endtask

  task automatic t_route();
    check("R8 route off", up_err, 0);
    set_ctl(1'b1, 1'b1);
    check("R8 route on", up_err, 1);
    set_ctl(1'b1, 1'b0);
    check("R8 route removed", up_err, 0);
  endtask

  task automatic t_novalid();
    rearm();
    @(negedge clk);
    rd_valid = 1'b0; rd_addr = 21'h100000; rd_data = 32'h0; rd_par = 4'h0;
    repeat (3) @(negedge clk);
    check("R10 strobe low", err_flag, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wr_parity();
    t_clean_read();
    t_single_error();
    t_lowest_lane();
    t_sticky();
    t_disable();
    t_onchip();
    t_route();
    t_novalid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule